// File: doc/BRIEF.md
# Chunked I2C Master Controller

This block is an I2C bus master that moves payload in chunks of up to 32 bytes through a pair of on-chip FIFOs. It does not need host service after every byte. The host works through a small word-wide register port. It flushes the FIFOs and loads a chunk length. For a write it also pushes the payload bytes. A write to the transfer register then starts the bus activity: START, the address byte, and the data bytes with acknowledge handling. When a chunk completes, the block sets a status flag and can raise an interrupt. It then either issues STOP, if the host marked this chunk as the last one for the current direction, or it parks the bus with SCL low until the host signals that the next chunk is ready.

A byte-at-a-time mode is also available. With the FIFO-mode control bit clear, every chunk is exactly one byte long and each byte completion sets its own status flag.

The transfer sequencer (`i2cm_seq`) has six states:
- S_IDLE goes to S_START on a transfer-register write.
- S_START goes to S_ADDR when the START condition is done.
- S_ADDR goes to S_DATA on ACK, or to S_STOP on NACK.
- S_DATA repeats for each byte. After the last byte of a chunk it goes to S_STOP if the end flag is set, and to S_PAUSE if it is not. A write-data NACK sends it to S_STOP.
- S_PAUSE goes to S_DATA when the host sets the ready bit.
- S_STOP goes to S_IDLE.

A master reset forces S_IDLE from any state.

The bit engine (`i2cm_bitengine`) walks through nine states:
- Idle, then E_ST_A, E_ST_B, E_ST_C for START.
- E_BIT_LO and E_BIT_HI, alternating nine times for each byte.
- E_SP_A, E_SP_B, E_SP_C for STOP.

Every state lasts one half-period.

Top module: `i2c_chunk_master`

Register offsets on `reg_addr`:

| Offset | Register | Notes |
|---|---|---|
| 0 | control | |
| 1 | transfer | |
| 2 | status | write-one-to-clear; bit 15 reads busy |
| 3 | mask | |
| 4 | timing | |
| 5 | flush | |
| 6 | TX data | |
| 7 | RX data | |
| 8 | TX length | |
| 9 | RX length | |

## Requirements
- R1: After reset, `busy` and `irq` are 0, both bus lines are released (1), and the status register reads 0.
- R2: A write to the transfer register (offset 1) carries the target address in bits [6:0] and the read direction in bit 8. It produces START followed by the byte {address, direction}, MSB first. `busy` is 1 from that write until STOP completes.
- R3: In FIFO mode (control bit 14 set), a write chunk sends TX-length+1 bytes taken from the TX FIFO in push order, MSB first.
- R4: After the last byte of a chunk, status bit 3 is set. If the end flag for the direction is set (control bit 1 for write, bit 2 for read), STOP follows. Otherwise SCL stays low, no STOP occurs, and `busy` stays 1 until a control write with bit 0 set. The next chunk then uses the length registers as they are at that moment.
- R5: A read chunk places RX-length+1 received bytes into the RX FIFO. Successive reads of offset 7 return them in order in bits [7:0]. The master ACKs every byte except the last byte of a chunk whose end flag is set, which it NACKs.
- R6: An unacknowledged address byte sets status bit 1, moves no data, and ends with STOP.
- R7: An unacknowledged write-data byte sets status bit 4 and ends with STOP, without setting bit 3.
- R8: Writing 1 to a status bit clears it. `irq` is the OR over the status bits ANDed with the mask register (same bit positions).
- R9: Writing the flush register empties the TX FIFO when bit 0 is set and the RX FIFO when bit 1 is set.
- R10: In byte mode (control bit 14 clear), each chunk is one byte regardless of the length registers, and its completion sets status bit 0 instead of bit 3.
- R11: SCL high and low phases each last timing[7:0]+1 clock cycles.
- R12: A control write with bit 7 set returns the controller to idle on the next cycle, with `busy` 0 and both lines released.
- R13: Each FIFO holds 32 bytes. A push into a full FIFO is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst | input | 1 | synchronous reset, active high |
| reg_we | input | 1 | register write strobe |
| reg_re | input | 1 | register read strobe; read data valid next cycle |
| reg_addr | input | 4 | register offset |
| reg_wdata | input | 16 | write data |
| reg_rdata | output | 16 | registered read data |
| irq | output | 1 | masked status interrupt |
| busy | output | 1 | transfer in progress |
| scl_rel | output | 1 | SCL: 1 releases the line, 0 pulls it low |
| sda_rel | output | 1 | SDA: 1 releases the line, 0 pulls it low |
| sda_in | input | 1 | SDA line level |

## Verification
Register effects land one cycle after the write strobe. `busy` is therefore sampled at the falling edge right after the write, and read data at the falling edge one cycle after the read strobe. Bus results arrive many half-periods later, so the bench polls `busy` or `irq` against a cycle bound, and only then checks status, stop counts and the queues of expected bytes. A bus-target model pops each received write byte from the driver's expected queue as it finishes. It also measures the SCL high time at every falling edge, so the half-period is checked at the point it occurs.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [1:0] {CMD_START, CMD_WRITE, CMD_READ, CMD_STOP} eng_cmd_e;

    typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR, S_DATA, S_PAUSE, S_STOP} seq_state_e;

    typedef enum logic [3:0] {
        E_IDLE, E_ST_A, E_ST_B, E_ST_C, E_BIT_LO, E_BIT_HI, E_SP_A, E_SP_B, E_SP_C
    } eng_state_e;

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_XFER   = 4'd1;
    localparam logic [3:0] A_STAT   = 4'd2;
    localparam logic [3:0] A_MASK   = 4'd3;
    localparam logic [3:0] A_TIMING = 4'd4;
    localparam logic [3:0] A_FLUSH  = 4'd5;
    localparam logic [3:0] A_TXDAT  = 4'd6;
    localparam logic [3:0] A_RXDAT  = 4'd7;
    localparam logic [3:0] A_TXLEN  = 4'd8;
    localparam logic [3:0] A_RXLEN  = 4'd9;

    localparam int ST_BYTE  = 0;
    localparam int ST_ANACK = 1;
    localparam int ST_FEND  = 3;
    localparam int ST_DNACK = 4;
    localparam int ST_W     = 5;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wptr, rptr;
    logic [AW:0]  count;

    assign count = wptr - rptr;
    assign full  = (count == (AW+1)'(DEPTH));
    assign empty = (count == '0);
    assign rdata = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push && !full) wptr <= wptr + 1'b1;
            if (pop && !empty) rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wptr[AW-1:0]] <= wdata;
    end

    // R13: a push into a full FIFO leaves the write pointer unchanged
    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> $stable(wptr));
endmodule

// File: rtl/i2cm_bitengine.sv
module i2cm_bitengine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       abort,
    input  logic [7:0] half_period,
    input  logic       cmd_go,
    input  eng_cmd_e   cmd,
    input  logic [7:0] wr_byte,
    input  logic       ack_out,
    input  logic       sda_in,
    output logic       ready,
    output logic       done,
    output logic [7:0] rd_byte,
    output logic       ack_in,
    output logic       scl_rel,
    output logic       sda_rel
);
    eng_state_e state, nxt;
    logic [7:0] cnt;
    logic       tick;
    logic [3:0] bitn;
    logic [8:0] txs;
    logic [8:0] rxs;
    logic       scl_q, sda_q;

    assign tick    = (cnt == half_period);
    assign ready   = (state == E_IDLE);
    assign rd_byte = rxs[8:1];
    assign ack_in  = rxs[0];
    assign scl_rel = scl_q;
    assign sda_rel = sda_q;

    always_ff @(posedge clk) begin
        if (rst || abort) state <= E_IDLE;
        else              state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            E_IDLE: if (cmd_go) begin
                unique case (cmd)
                    CMD_START: nxt = E_ST_A;
                    CMD_WRITE: nxt = E_BIT_LO;
                    CMD_READ:  nxt = E_BIT_LO;
                    CMD_STOP:  nxt = E_SP_A;
                endcase
            end
            E_ST_A:   if (tick) nxt = E_ST_B;
            E_ST_B:   if (tick) nxt = E_ST_C;
            E_ST_C:   if (tick) nxt = E_IDLE;
            E_BIT_LO: if (tick) nxt = E_BIT_HI;
            E_BIT_HI: if (tick) nxt = (bitn == 4'd0) ? E_IDLE : E_BIT_LO;
            E_SP_A:   if (tick) nxt = E_SP_B;
            E_SP_B:   if (tick) nxt = E_SP_C;
            E_SP_C:   if (tick) nxt = E_IDLE;
            default:  nxt = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            cnt   <= '0;
            done  <= 1'b0;
            bitn  <= '0;
            txs   <= '1;
            rxs   <= '0;
        end else begin
            done <= 1'b0;
            cnt  <= (state == E_IDLE || tick) ? 8'd0 : cnt + 8'd1;
            unique case (state)
                E_IDLE: if (cmd_go) begin
                    unique case (cmd)
                        CMD_START: begin scl_q <= 1'b1; sda_q <= 1'b1; end
                        CMD_WRITE: begin
                            txs   <= {wr_byte, 1'b1};
                            bitn  <= 4'd8;
                            scl_q <= 1'b0;
                            sda_q <= wr_byte[7];
                        end
                        CMD_READ: begin
                            txs   <= {8'hFF, ack_out};
                            bitn  <= 4'd8;
                            scl_q <= 1'b0;
                            sda_q <= 1'b1;
                        end
                        CMD_STOP: begin scl_q <= 1'b0; sda_q <= 1'b0; end
                    endcase
                end
                E_ST_A:   if (tick) sda_q <= 1'b0;
                E_ST_B:   if (tick) scl_q <= 1'b0;
                E_ST_C:   if (tick) done  <= 1'b1;
                E_BIT_LO: if (tick) scl_q <= 1'b1;
                E_BIT_HI: if (tick) begin
                    rxs   <= {rxs[7:0], sda_in};
                    scl_q <= 1'b0;
                    if (bitn == 4'd0) begin
                        done <= 1'b1;
                    end else begin
                        bitn  <= bitn - 4'd1;
                        sda_q <= txs[bitn-4'd1];
                    end
                end
                E_SP_A:   if (tick) scl_q <= 1'b1;
                E_SP_B:   if (tick) sda_q <= 1'b1;
                E_SP_C:   if (tick) done  <= 1'b1;
                default: ;
            endcase
        end
    end

    // R11: SCL stays high for the whole high phase of a bit
    assert_scl_high_phase_R11: assert property (@(posedge clk) disable iff (rst || abort)
        (state == E_BIT_HI && !tick) |=> scl_rel);
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mrst,
    input  logic          fifo_mode,
    input  logic          tx_end,
    input  logic          rx_end,
    input  logic          start_req,
    input  logic [6:0]    start_addr,
    input  logic          start_rd,
    input  logic          cpu_ready,
    input  logic [LW-1:0] tx_len,
    input  logic [LW-1:0] rx_len,
    input  logic [7:0]    tx_data,
    input  logic          eng_ready,
    input  logic          eng_done,
    input  logic [7:0]    eng_rd_byte,
    input  logic          eng_ack_in,
    output logic          eng_go,
    output eng_cmd_e      eng_cmd,
    output logic [7:0]    eng_wr_byte,
    output logic          eng_ack_out,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [7:0]    rx_byte,
    output logic          busy,
    output logic [ST_W-1:0] set_stat
);
    localparam int CW = LW + 1;

    seq_state_e state, nxt;
    logic [6:0]    addr_q;
    logic          rd_q;
    logic [CW-1:0] remain;
    logic          issued;
    logic          last, end_flag, data_done, wr_nack;
    logic [CW-1:0] chunk_len;

    assign last      = (remain == CW'(1));
    assign end_flag  = rd_q ? rx_end : tx_end;
    assign data_done = (state == S_DATA) && eng_done;
    assign wr_nack   = data_done && !rd_q && eng_ack_in;
    assign chunk_len = !fifo_mode ? CW'(1)
                     : (rd_q ? CW'(rx_len) + CW'(1) : CW'(tx_len) + CW'(1));

    always_ff @(posedge clk) begin
        if (rst || mrst) state <= S_IDLE;
        else             state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start_req) nxt = S_START;
            S_START: if (eng_done) nxt = S_ADDR;
            S_ADDR:  if (eng_done) nxt = eng_ack_in ? S_STOP : S_DATA;
            S_DATA:  if (eng_done) begin
                if (wr_nack)   nxt = S_STOP;
                else if (last) nxt = end_flag ? S_STOP : S_PAUSE;
            end
            S_PAUSE: if (cpu_ready) nxt = S_DATA;
            S_STOP:  if (eng_done) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        eng_go      = 1'b0;
        eng_cmd     = CMD_START;
        eng_wr_byte = tx_data;
        unique case (state)
            S_START: begin eng_go = !issued && eng_ready; eng_cmd = CMD_START; end
            S_ADDR: begin
                eng_go      = !issued && eng_ready;
                eng_cmd     = CMD_WRITE;
                eng_wr_byte = {addr_q, rd_q};
            end
            S_DATA: begin
                eng_go  = !issued && eng_ready;
                eng_cmd = rd_q ? CMD_READ : CMD_WRITE;
            end
            S_STOP:  begin eng_go = !issued && eng_ready; eng_cmd = CMD_STOP; end
            default: ;
        endcase
        eng_ack_out = last && end_flag;
        tx_pop      = eng_go && (state == S_DATA) && !rd_q;
        rx_push     = data_done && rd_q;
        rx_byte     = eng_rd_byte;
        busy        = (state != S_IDLE);
        set_stat    = '0;
        set_stat[ST_ANACK] = (state == S_ADDR) && eng_done && eng_ack_in;
        set_stat[ST_DNACK] = wr_nack;
        set_stat[ST_FEND]  = data_done && last && !wr_nack && fifo_mode;
        set_stat[ST_BYTE]  = data_done && last && !wr_nack && !fifo_mode;
    end

    always_ff @(posedge clk) begin
        if (rst || mrst) begin
            issued <= 1'b0;
            addr_q <= '0;
            rd_q   <= 1'b0;
            remain <= '0;
        end else begin
            if (eng_go)        issued <= 1'b1;
            else if (eng_done) issued <= 1'b0;
            if (state == S_IDLE && start_req) begin
                addr_q <= start_addr;
                rd_q   <= start_rd;
                remain <= !fifo_mode ? CW'(1)
                        : (start_rd ? CW'(rx_len) + CW'(1) : CW'(tx_len) + CW'(1));
            end
            if (data_done)                       remain <= remain - CW'(1);
            if (state == S_PAUSE && cpu_ready)   remain <= chunk_len;
        end
    end

    // R12: master reset returns to idle on the next cycle
    assert_mrst_idle_R12: assert property (@(posedge clk) disable iff (rst)
        mrst |=> (state == S_IDLE) && !busy);

    // R6: an address NACK seen from the engine leads straight to STOP
    assert_addr_nack_stop_R6: assert property (@(posedge clk) disable iff (rst || mrst)
        (state == S_ADDR && eng_done && eng_ack_in) |=> (state == S_STOP));
endmodule

// File: rtl/i2c_chunk_master.sv
module i2c_chunk_master
    import i2cm_pkg::*;
#(
    parameter int FIFO_DEPTH  = 32,
    parameter int RESET_HALF  = 99
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        busy,
    output logic        scl_rel,
    output logic        sda_rel,
    input  logic        sda_in
);
    localparam int LW = $clog2(FIFO_DEPTH);

    logic          fifo_mode, tx_end, rx_end;
    logic [ST_W-1:0] mask_q, status_q, set_stat, w1c;
    logic [7:0]    timing_q;
    logic [LW-1:0] txlen_q, rxlen_q;
    logic [15:0]   rdata_q;

    logic wr_ctrl, cpu_ready, mrst, start_req;
    logic tx_flush, rx_flush, tx_push, rx_pop;
    logic tx_pop, rx_push;
    logic [7:0] tx_head, rx_head, rx_byte;
    logic tx_empty, tx_full, rx_empty, rx_full;

    logic       eng_go, eng_ready, eng_done, eng_ack_in, eng_ack_out;
    eng_cmd_e   eng_cmd;
    logic [7:0] eng_wr_byte, eng_rd_byte;

    assign wr_ctrl   = reg_we && (reg_addr == A_CTRL);
    assign cpu_ready = wr_ctrl && reg_wdata[0];
    assign mrst      = wr_ctrl && reg_wdata[7];
    assign start_req = reg_we && (reg_addr == A_XFER) && !busy;
    assign tx_flush  = reg_we && (reg_addr == A_FLUSH) && reg_wdata[0];
    assign rx_flush  = reg_we && (reg_addr == A_FLUSH) && reg_wdata[1];
    assign tx_push   = reg_we && (reg_addr == A_TXDAT);
    assign rx_pop    = reg_re && (reg_addr == A_RXDAT);
    assign w1c       = (reg_we && reg_addr == A_STAT) ? reg_wdata[ST_W-1:0] : '0;

    assign irq       = |(status_q & mask_q);
    assign reg_rdata = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_mode <= 1'b0;
            tx_end    <= 1'b0;
            rx_end    <= 1'b0;
            mask_q    <= '0;
            status_q  <= '0;
            timing_q  <= 8'(RESET_HALF);
            txlen_q   <= '0;
            rxlen_q   <= '0;
            rdata_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                fifo_mode <= reg_wdata[14];
                tx_end    <= reg_wdata[1];
                rx_end    <= reg_wdata[2];
            end
            if (reg_we && reg_addr == A_MASK)   mask_q   <= reg_wdata[ST_W-1:0];
            if (reg_we && reg_addr == A_TIMING) timing_q <= reg_wdata[7:0];
            if (reg_we && reg_addr == A_TXLEN)  txlen_q  <= reg_wdata[LW-1:0];
            if (reg_we && reg_addr == A_RXLEN)  rxlen_q  <= reg_wdata[LW-1:0];
            status_q <= (status_q & ~w1c) | set_stat;
            if (reg_re) begin
                unique case (reg_addr)
                    A_CTRL:   rdata_q <= {1'b0, fifo_mode, 11'b0, rx_end, tx_end, 1'b0};
                    A_STAT:   rdata_q <= {busy, 10'b0, status_q};
                    A_MASK:   rdata_q <= {11'b0, mask_q};
                    A_TIMING: rdata_q <= {8'b0, timing_q};
                    A_TXLEN:  rdata_q <= 16'(txlen_q);
                    A_RXLEN:  rdata_q <= 16'(rxlen_q);
                    A_RXDAT:  rdata_q <= {8'b0, rx_head};
                    default:  rdata_q <= '0;
                endcase
            end
        end
    end

    i2cm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(tx_push), .wdata(reg_wdata[7:0]),
        .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full)
    );

    i2cm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(rx_push), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
    );

    i2cm_seq #(.LW(LW)) u_seq (
        .clk(clk), .rst(rst), .mrst(mrst),
        .fifo_mode(fifo_mode), .tx_end(tx_end), .rx_end(rx_end),
        .start_req(start_req), .start_addr(reg_wdata[6:0]), .start_rd(reg_wdata[8]),
        .cpu_ready(cpu_ready), .tx_len(txlen_q), .rx_len(rxlen_q), .tx_data(tx_head),
        .eng_ready(eng_ready), .eng_done(eng_done),
        .eng_rd_byte(eng_rd_byte), .eng_ack_in(eng_ack_in),
        .eng_go(eng_go), .eng_cmd(eng_cmd), .eng_wr_byte(eng_wr_byte),
        .eng_ack_out(eng_ack_out), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_byte(rx_byte), .busy(busy), .set_stat(set_stat)
    );

    i2cm_bitengine u_eng (
        .clk(clk), .rst(rst), .abort(mrst), .half_period(timing_q),
        .cmd_go(eng_go), .cmd(eng_cmd), .wr_byte(eng_wr_byte), .ack_out(eng_ack_out),
        .sda_in(sda_in), .ready(eng_ready), .done(eng_done),
        .rd_byte(eng_rd_byte), .ack_in(eng_ack_in),
        .scl_rel(scl_rel), .sda_rel(sda_rel)
    );

    // R4: when a transfer ends after STOP both lines are released
    assert_stop_release_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(mrst)) |-> (scl_rel && sda_rel));

    // R8: a full write-one-to-clear with no new event empties the status
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
        ((&w1c) && (set_stat == '0)) |=> (status_q == '0));
endmodule

// File: tb/i2c_chunk_master_test.sv
module i2c_chunk_master_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, busy, scl_rel, sda_rel, sda_in;
    logic        tgt_rel = 1'b1;

    assign sda_in = sda_rel & tgt_rel;
    always #5 clk = ~clk;

    i2c_chunk_master uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .busy(busy),
        .scl_rel(scl_rel), .sda_rel(sda_rel), .sda_in(sda_in)
    );

    int n_chk = 0, n_err = 0;
    logic [7:0] exp_wr[$];
    localparam logic [6:0] TADDR = 7'h2A;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_pat(input int i);
        return 8'hC0 + 8'(i);
    endfunction

    // bus-target model and monitor
    logic scl_p = 1'b1, sda_p = 1'b1;
    int   bc = 0, ph = 0, widx = 0, ridx = 0, nack_at = -1;
    int   n_stop = 0, n_mnack = 0, mnack_idx = -1, hi_cnt = 0, last_hi = 0;
    logic [7:0] sh = '0, addr_seen = '0, cur;
    logic aok = 1'b0, adir = 1'b0, wnack = 1'b0, mack = 1'b0;

    always @(negedge clk) begin
        logic bscl, bsda;
        bscl = scl_rel;
        bsda = sda_rel & tgt_rel;
        if (bscl && scl_p && sda_p && !bsda) begin
            ph = 1; bc = -1; ridx = 0;
        end else if (bscl && scl_p && !sda_p && bsda) begin
            ph = 0; n_stop++; tgt_rel = 1'b1;
        end else if (bscl && !scl_p) begin
            if (ph != 0 && ph != 3 && bc >= 0 && bc < 8) sh = {sh[6:0], bsda};
            if (ph == 3 && bc == 8) mack = bsda;
        end else if (!bscl && scl_p) begin
            last_hi = hi_cnt;
            if (ph != 0) begin
                if (bc < 8) begin
                    bc++;
                    if (ph == 3) begin
                        cur = rd_pat(ridx);
                        tgt_rel = (bc < 8) ? cur[7-bc] : 1'b1;
                    end else if (bc == 8) begin
                        if (ph == 1) begin
                            addr_seen = sh;
                            aok = (sh[7:1] == TADDR);
                            adir = sh[0];
                            tgt_rel = !aok;
                        end else begin
                            // monitor: compare against the driver's queue (R3)
                            if (exp_wr.size() == 0) check(1'b0, "R3 unexpected byte", sh, 0);
                            else begin
                                cur = exp_wr.pop_front();
                                check(sh == cur, "R3 write byte", sh, cur);
                            end
                            wnack = (widx == nack_at);
                            tgt_rel = wnack;
                            widx++;
                        end
                    end
                end else begin
                    bc = 0;
                    tgt_rel = 1'b1;
                    if (ph == 1) ph = aok ? (adir ? 3 : 2) : 0;
                    else if (ph == 2) begin if (wnack) ph = 0; end
                    else if (ph == 3) begin
                        if (mack) begin ph = 0; n_mnack++; mnack_idx = ridx; end
                        ridx++;
                    end
                    if (ph == 3) begin cur = rd_pat(ridx); tgt_rel = cur[7]; end
                end
            end
        end
        hi_cnt = bscl ? hi_cnt + 1 : 0;
        scl_p = bscl;
        sda_p = bsda;
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); reg_re = 1'b1; reg_addr = a;
        @(negedge clk); reg_re = 1'b0; d = reg_rdata;
    endtask

    task automatic push_tx(input logic [7:0] b, input logic expect_it);
        wr(4'd6, {8'h00, b});
        if (expect_it) exp_wr.push_back(b);
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
        check(!busy, tag, busy, 0);
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 20000) begin @(negedge clk); n++; end
        check(irq, tag, irq, 1);
    endtask

    logic [15:0] d;
    int s0, w0, m0;
    bit done_flag = 0;

    initial begin
        #(200000 * 10);
        if (!done_flag) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !irq, "R1 busy/irq", {busy, irq}, 0);
        check(scl_rel && sda_rel, "R1 lines", {scl_rel, sda_rel}, 3);
        rd(4'd2, d); check(d == 0, "R1 status", d, 0);

        wr(4'd4, 16'd3);            // half period 4 cycles
        wr(4'd3, 16'h001B);         // unmask bits 0,1,3,4

        // single write chunk with end flag
        s0 = n_stop;
        wr(4'd0, 16'h4002);
        wr(4'd5, 16'h0003);
        push_tx(8'h11, 1); push_tx(8'hA2, 1); push_tx(8'h3C, 1);
        wr(4'd8, 16'd2);
        wr(4'd1, {9'd0, TADDR});
        check(busy, "R2 busy after start", busy, 1);
        wait_idle("R2 busy clears");
        check(addr_seen == {TADDR, 1'b0}, "R2 address byte", addr_seen, {TADDR, 1'b0});
        check(exp_wr.size() == 0, "R3 all bytes sent", exp_wr.size(), 0);
        check(n_stop == s0 + 1, "R4 stop after end chunk", n_stop, s0 + 1);
        check(last_hi == 4, "R11 scl high time", last_hi, 4);
        rd(4'd2, d); check(d == 16'h0008, "R4 fifo-end status", d, 16'h0008);
        check(irq, "R8 irq unmasked", irq, 1);
        wr(4'd3, 16'h0000);
        check(!irq, "R8 irq masked", irq, 0);
        wr(4'd3, 16'h001B);
        wr(4'd2, 16'h0008);
        rd(4'd2, d); check(d == 0 && !irq, "R8 w1c clear", d, 0);

        // two chunks, overflow and flush
        s0 = n_stop;
        wr(4'd0, 16'h4000);
        push_tx(8'h77, 0);
        wr(4'd5, 16'h0001);         // R9: stale byte dropped
        for (int i = 0; i < 33; i++) push_tx(8'(i), i < 32);  // R13: 33rd dropped
        wr(4'd8, 16'd31);
        wr(4'd1, {9'd0, TADDR});
        wait_irq("R4 chunk irq");
        rd(4'd2, d); check(d == 16'h8008, "R4 paused status", d, 16'h8008);
        repeat (50) @(negedge clk);
        check(!scl_rel && busy, "R4 bus held", {scl_rel, busy}, 1);
        check(n_stop == s0, "R4 no stop in pause", n_stop, s0);
        check(exp_wr.size() == 0, "R9 first chunk content", exp_wr.size(), 0);
        wr(4'd2, 16'h001F);
        for (int i = 0; i < 8; i++) push_tx(8'h80 + 8'(i), 1);
        wr(4'd8, 16'd7);
        wr(4'd0, 16'h4003);
        wait_idle("R4 second chunk");
        check(exp_wr.size() == 0, "R13 second chunk content", exp_wr.size(), 0);
        check(n_stop == s0 + 1, "R4 stop after last chunk", n_stop, s0 + 1);
        wr(4'd2, 16'h001F);

        // read chunk
        m0 = n_mnack;
        wr(4'd0, 16'h4004);
        wr(4'd5, 16'h0003);
        wr(4'd9, 16'd4);
        wr(4'd1, {7'd0, 1'b1, 1'b0, TADDR});
        wait_idle("R5 read done");
        for (int i = 0; i < 5; i++) begin
            rd(4'd7, d);
            check(d[7:0] == rd_pat(i), "R5 read byte", d[7:0], rd_pat(i));
        end
        check(n_mnack == m0 + 1 && mnack_idx == 4, "R5 nack on last", mnack_idx, 4);
        rd(4'd2, d); check(d == 16'h0008, "R5 fifo-end", d, 16'h0008);
        wr(4'd2, 16'h001F);

        // address NACK
        s0 = n_stop; w0 = widx;
        wr(4'd0, 16'h4002);
        wr(4'd1, 16'h0033);
        wait_idle("R6 done");
        rd(4'd2, d); check(d == 16'h0002, "R6 addr nack status", d, 16'h0002);
        check(n_stop == s0 + 1 && widx == w0, "R6 stop no data", widx, w0);
        wr(4'd2, 16'h001F);

        // data NACK
        nack_at = widx + 1;
        wr(4'd5, 16'h0003);
        push_tx(8'hD1, 1); push_tx(8'hD2, 1); push_tx(8'hD3, 0);
        wr(4'd8, 16'd2);
        wr(4'd1, {9'd0, TADDR});
        wait_idle("R7 done");
        rd(4'd2, d); check(d == 16'h0010, "R7 data nack status", d, 16'h0010);
        check(exp_wr.size() == 0, "R7 bytes before nack", exp_wr.size(), 0);
        nack_at = -1;
        wr(4'd2, 16'h001F);
        wr(4'd5, 16'h0003);

        // byte mode
        w0 = widx;
        wr(4'd0, 16'h0000);
        push_tx(8'h5C, 1); push_tx(8'h6D, 1);
        wr(4'd8, 16'd7);
        wr(4'd1, {9'd0, TADDR});
        wait_irq("R10 byte irq");
        rd(4'd2, d); check(d == 16'h8001, "R10 byte status", d, 16'h8001);
        check(widx == w0 + 1, "R10 one byte per step", widx, w0 + 1);
        wr(4'd2, 16'h001F);
        wr(4'd0, 16'h0003);
        wait_idle("R10 second byte");
        check(widx == w0 + 2 && exp_wr.size() == 0, "R10 second byte sent", widx, w0 + 2);
        wr(4'd2, 16'h001F);

        // master reset mid-transfer
        wr(4'd0, 16'h4000);
        wr(4'd9, 16'd31);
        wr(4'd1, {7'd0, 1'b1, 1'b0, TADDR});
        repeat (60) @(negedge clk);
        wr(4'd0, 16'h0080);
        check(!busy && scl_rel && sda_rel, "R12 reset to idle", {busy, scl_rel, sda_rel}, 3'b011);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule